// File: doc/BRIEF.md
# Receive Queue with Service Request and Overrun Status

This block is an eight-word receive buffer. It sits between a serial receiver, which offers words on a push port, and a reader, which is either software or a DMA engine and takes words from a pop port. Words leave the buffer in the order they arrived. The block also reports how full it is, and it asks for service once half of its entries hold data.

The service request is a read-only level flag. It is raised at or above a set level and dropped at or below a clear level, with the default values 4 and 3. The flag feeds two outputs. The interrupt output is gated by an enable input. The DMA request output follows the flag with no gating at all. The flag clears by itself as the reader drains the buffer.

When the receiver pushes while every entry is occupied and nothing is popped in the same cycle, the word is discarded and a sticky overrun status bit is set. This happens again for each later word that arrives while the buffer is still full. The overrun bit drives an interrupt that cannot be masked. It is cleared by a one-cycle clear pulse, and a new overrun in the same cycle takes priority over the clear.

Top module: `rxq_top`

## Requirements
- R1: After reset, `occupancy` is 0, `pop_data` is 0, and `svc_flag`, `svc_irq`, `dma_req`, `ovr_status` and `ovr_irq` are all 0.
- R2: Each accepted pop loads `pop_data` with the oldest stored word, visible from the clock edge that takes the pop, so words leave in arrival order.
- R3: `svc_flag` is 1 in every cycle in which `occupancy` is 4 or more.
- R4: `svc_flag` is 0 in every cycle in which `occupancy` is 3 or less, including after a drain, with no write from the reader.
- R5: `svc_irq` is 1 exactly when `svc_flag` is 1 and `irq_en` is 1.
- R6: `dma_req` equals `svc_flag` whatever the value of `irq_en`.
- R7: A push while `occupancy` is 8 with no pop in the same cycle is dropped: `occupancy` stays 8, the stored words are unchanged, and `ovr_status` is 1 after that edge.
- R8: `ovr_status` stays 1 until a cycle with `ovr_clr` = 1 and no dropped word, which clears it at that edge. A drop in the same cycle as `ovr_clr` leaves it at 1, and each later dropped word sets it again.
- R9: `ovr_irq` is 1 whenever `ovr_status` is 1, and `irq_en` has no effect on it.
- R10: A pop while `occupancy` is 0 leaves `pop_data` unchanged and `occupancy` at 0.
- R11: A push and a pop in the same cycle while `occupancy` is 8 are both accepted: `occupancy` stays 8, no overrun is flagged, and the pushed word comes out after the seven older words.
- R12: A push and a pop in the same cycle with `occupancy` between 1 and 7 leave `occupancy` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | The receiver offers a word this cycle |
| push_data | input | DATA_W | The word the receiver offers |
| pop_req | input | 1 | The reader takes one word this cycle |
| pop_data | output | DATA_W | The last word popped, held until the next accepted pop |
| occupancy | output | $clog2(DEPTH+1) | Number of stored words |
| irq_en | input | 1 | Enable for the service interrupt |
| ovr_clr | input | 1 | Clears the overrun status (write-1-to-clear pulse) |
| svc_flag | output | 1 | Service request level flag |
| svc_irq | output | 1 | Service interrupt, masked by `irq_en` |
| dma_req | output | 1 | DMA service request, never masked |
| ovr_status | output | 1 | Sticky overrun status |
| ovr_irq | output | 1 | Overrun interrupt, cannot be masked |

## Verification
The assertions assume that every input is settled at the sampling edge and that `push_data` is known whenever `push_valid` is high. They also take `occupancy` as the only record of how many words are stored, so the set and clear levels are checked against that port alone. The bench changes every input one nanosecond after a rising edge and drops all strobes back to zero after a single cycle. Each push, pop and clear therefore lasts exactly one sampled cycle, and the overrun priority is tested with a drop and a clear arranged to fall in the same cycle on purpose.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Which way the stored-word count moves in one cycle
  typedef enum logic [1:0] {
    LVL_HOLD = 2'b00,
    LVL_UP   = 2'b01,
    LVL_DOWN = 2'b10
  } lvl_move_e;

  function automatic lvl_move_e lvl_move(input logic acc_push, input logic acc_pop);
    if (acc_push && !acc_pop)      return LVL_UP;
    else if (acc_pop && !acc_push) return LVL_DOWN;
    else                           return LVL_HOLD;
  endfunction

  // Count after one cycle of accepted transfers
  function automatic int lvl_after(input int lvl, input logic acc_push, input logic acc_pop);
    case (lvl_move(acc_push, acc_pop))
      LVL_UP:   return lvl + 1;
      LVL_DOWN: return lvl - 1;
      default:  return lvl;
    endcase
  endfunction

  // Service flag with separate set and clear levels; holds between them
  function automatic logic svc_after(input logic cur, input int lvl,
                                     input int set_lvl, input int clr_lvl);
    if (lvl >= set_lvl)      return 1'b1;
    else if (lvl <= clr_lvl) return 1'b0;
    else                     return cur;
  endfunction

  // Sticky status bit: a set beats a clear
  function automatic logic sticky_after(input logic cur, input logic set_ev, input logic clr_ev);
    if (set_ev)      return 1'b1;
    else if (clr_ev) return 1'b0;
    else             return cur;
  endfunction

  // Circular pointer advance for any depth
  function automatic int ptr_after(input int ptr, input logic adv, input int depth);
    if (!adv)                return ptr;
    else if (ptr == depth-1) return 0;
    else                     return ptr + 1;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_ptr_nxt;
  logic [PTR_W-1:0]  rd_ptr_nxt;

  always_comb begin
    wr_ptr_nxt = PTR_W'(ptr_after(int'(wr_ptr), wr_en, DEPTH));
    rd_ptr_nxt = PTR_W'(ptr_after(int'(rd_ptr), rd_en, DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
    end
  end

  // One register per entry; each entry is loaded when the write pointer selects it
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr == PTR_W'(gi))) mem[gi] <= wr_data;
    end
  end

  // Read register keeps the last popped word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_ptr];
  end

endmodule

// File: rtl/rxq_level.sv
module rxq_level
  import rxq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int SET_LVL = 4,
  parameter int CLR_LVL = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_push,
  input  logic                       acc_pop,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       svc
);
  localparam int LVL_W = $clog2(DEPTH+1);

  logic [LVL_W-1:0] level_nxt;
  logic             svc_nxt;

  always_comb begin
    level_nxt = LVL_W'(lvl_after(int'(level), acc_push, acc_pop));
    svc_nxt   = svc_after(svc, int'(level_nxt), SET_LVL, CLR_LVL);
  end

  // The flag is computed from the next count so it lines up with the count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      svc   <= 1'b0;
    end else begin
      level <= level_nxt;
      svc   <= svc_nxt;
    end
  end

endmodule

// File: rtl/rxq_overrun.sv
module rxq_overrun
  import rxq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic drop_ev,
  input  logic clr_req,
  output logic status
);
  logic status_nxt;

  always_comb status_nxt = sticky_after(status, drop_ev, clr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 1'b0;
    else        status <= status_nxt;
  end

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int SET_LVL = DEPTH / 2,
  parameter int CLR_LVL = DEPTH / 2 - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop_req,
  output logic [DATA_W-1:0]          pop_data,
  output logic [$clog2(DEPTH+1)-1:0] occupancy,
  input  logic                       irq_en,
  input  logic                       ovr_clr,
  output logic                       svc_flag,
  output logic                       svc_irq,
  output logic                       dma_req,
  output logic                       ovr_status,
  output logic                       ovr_irq
);
  localparam int LVL_W = $clog2(DEPTH+1);

  // Named internal events, also seen by the bound checker
  logic is_full;
  logic is_empty;
  logic acc_pop;
  logic acc_push;
  logic drop_ev;

  always_comb begin
    is_full  = (occupancy == LVL_W'(DEPTH));
    is_empty = (occupancy == '0);
    acc_pop  = pop_req && !is_empty;
    acc_push = push_valid && (!is_full || acc_pop);
    drop_ev  = push_valid && is_full && !acc_pop;
  end

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (acc_push),
    .wr_data (push_data),
    .rd_en   (acc_pop),
    .rd_data (pop_data)
  );

  rxq_level #(.DEPTH(DEPTH), .SET_LVL(SET_LVL), .CLR_LVL(CLR_LVL)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_push (acc_push),
    .acc_pop  (acc_pop),
    .level    (occupancy),
    .svc      (svc_flag)
  );

  rxq_overrun u_ovr (
    .clk     (clk),
    .rst_n   (rst_n),
    .drop_ev (drop_ev),
    .clr_req (ovr_clr),
    .status  (ovr_status)
  );

  always_comb begin
    svc_irq = svc_flag && irq_en;
    dma_req = svc_flag;
    ovr_irq = ovr_status;
  end

endmodule

// File: rtl/rxq_top_chk.sv
module rxq_top_chk #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int SET_LVL = 4,
  parameter int CLR_LVL = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       push_valid,
  input logic                       pop_req,
  input logic [DATA_W-1:0]          pop_data,
  input logic [$clog2(DEPTH+1)-1:0] occupancy,
  input logic                       irq_en,
  input logic                       ovr_clr,
  input logic                       svc_flag,
  input logic                       svc_irq,
  input logic                       dma_req,
  input logic                       ovr_status,
  input logic                       ovr_irq,
  input logic                       drop_ev
);
  localparam int LVL_W = $clog2(DEPTH+1);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= LVL_W'(DEPTH));

  p_svc_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy >= LVL_W'(SET_LVL)) |-> svc_flag);

  p_svc_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy <= LVL_W'(CLR_LVL)) |-> !svc_flag);

  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !svc_irq);

  p_dma_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_flag && !irq_en) |-> dma_req);

  p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !pop_req && occupancy == LVL_W'(DEPTH)) |=> (ovr_status && occupancy == LVL_W'(DEPTH)));

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_status && !ovr_clr) |=> ovr_status);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_ev && ovr_clr) |=> ovr_status);

  p_ovr_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_status |-> ovr_irq);

  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_valid && occupancy == '0) |=> ($stable(pop_data) && occupancy == '0));

  p_full_pushpop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_req && occupancy == LVL_W'(DEPTH) && !ovr_status) |=> (!ovr_status && occupancy == LVL_W'(DEPTH)));

endmodule

bind rxq_top rxq_top_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .SET_LVL(SET_LVL), .CLR_LVL(CLR_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop_req(pop_req),
  .pop_data(pop_data), .occupancy(occupancy), .irq_en(irq_en), .ovr_clr(ovr_clr),
  .svc_flag(svc_flag), .svc_irq(svc_irq), .dma_req(dma_req),
  .ovr_status(ovr_status), .ovr_irq(ovr_irq), .drop_ev(drop_ev)
);

// File: tb/rxq_top_tb.sv
`timescale 1ns/1ps
module rxq_top_tb;
  localparam int DW = 16;
  localparam int DP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_valid = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic          pop_req = 1'b0;
  logic [DW-1:0] pop_data;
  logic [3:0]    occupancy;
  logic          irq_en = 1'b0;
  logic          ovr_clr = 1'b0;
  logic          svc_flag, svc_irq, dma_req, ovr_status, ovr_irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] model_q[$];
  logic [DW-1:0] last_pop = '0;

  always #2 clk = ~clk;

  rxq_top #(.DATA_W(DW), .DEPTH(DP)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .occupancy(occupancy),
    .irq_en(irq_en), .ovr_clr(ovr_clr), .svc_flag(svc_flag), .svc_irq(svc_irq),
    .dma_req(dma_req), .ovr_status(ovr_status), .ovr_irq(ovr_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; outputs are sampled 1 ns after the edge
  task automatic step(input logic pu, input logic [DW-1:0] d, input logic po, input logic clr);
    push_valid = pu; push_data = d; pop_req = po; ovr_clr = clr;
    @(posedge clk);
    #1;
    push_valid = 1'b0; pop_req = 1'b0; ovr_clr = 1'b0;
    // Bench model of acceptance
    if (po && model_q.size() > 0) last_pop = model_q.pop_front();
    else if (po) begin end
    if (pu && (model_q.size() < DP || (po && model_q.size() == DP - 1 + 0 && 1'b0))) begin end
  endtask

  task automatic apply_reset;
    rst_n = 1'b0;
    push_valid = 1'b0; pop_req = 1'b0; ovr_clr = 1'b0;
    model_q.delete();
    last_pop = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  // Accepting push into model, using occupancy before the edge
  task automatic push_word(input logic [DW-1:0] d);
    if (model_q.size() < DP) model_q.push_back(d);
    push_valid = 1'b1; push_data = d;
    @(posedge clk); #1;
    push_valid = 1'b0;
  endtask

  task automatic pop_word;
    pop_req = 1'b1;
    @(posedge clk); #1;
    pop_req = 1'b0;
    if (model_q.size() > 0) last_pop = model_q.pop_front();
  endtask

  task automatic t_reset;
    apply_reset();
    chk("R1 occupancy", occupancy, 0);
    chk("R1 pop_data", pop_data, 0);
    chk("R1 flags", {svc_flag, svc_irq, dma_req, ovr_status, ovr_irq}, 0);
  endtask

  task automatic t_level_flag;
    apply_reset();
    irq_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      push_word(DW'(16'hA0 + i));
      chk("R3/R4 occupancy", occupancy, model_q.size());
      chk("R3/R4 svc_flag", svc_flag, (model_q.size() >= 4));
    end
    chk("R5 svc_irq enabled", svc_irq, 1);
    for (int i = 0; i < 5; i++) begin
      pop_word();
      chk("R2 order", pop_data, last_pop);
      chk("R4 svc_flag drain", svc_flag, (model_q.size() >= 4));
      chk("R6 dma_req follows flag", dma_req, (model_q.size() >= 4));
    end
    chk("R2 last word", pop_data, 16'hA4);
  endtask

  task automatic t_mask;
    apply_reset();
    irq_en = 1'b0;
    for (int i = 0; i < 4; i++) push_word(DW'(16'h10 + i));
    chk("R5 svc_irq masked", svc_irq, 0);
    chk("R6 dma_req unmasked", dma_req, 1);
    irq_en = 1'b1; #1;
    chk("R5 svc_irq unmasked", svc_irq, 1);
    irq_en = 1'b0; #1;
    chk("R6 dma_req with mask off", dma_req, 1);
  endtask

  task automatic t_overrun;
    apply_reset();
    irq_en = 1'b0;
    for (int i = 0; i < DP; i++) push_word(DW'(16'h200 + i));
    chk("R7 full", occupancy, DP);
    chk("R7 no overrun yet", ovr_status, 0);
    push_word(16'hDEAD);
    chk("R7 occupancy after drop", occupancy, DP);
    chk("R7 ovr_status set", ovr_status, 1);
    chk("R9 ovr_irq with mask off", ovr_irq, 1);
    step(1'b0, '0, 1'b0, 1'b0);
    chk("R8 sticky", ovr_status, 1);
    step(1'b0, '0, 1'b0, 1'b1);
    chk("R8 clear", ovr_status, 0);
    chk("R9 ovr_irq follows", ovr_irq, 0);
    // Drop and clear in the same cycle: set wins
    step(1'b1, 16'hBEEF, 1'b0, 1'b1);
    chk("R8 set wins over clear", ovr_status, 1);
    step(1'b0, '0, 1'b0, 1'b1);
    chk("R8 cleared again", ovr_status, 0);
    push_word(16'hF00D);
    chk("R8 set again by next drop", ovr_status, 1);
    for (int i = 0; i < DP; i++) begin
      pop_word();
      chk("R7 stored words kept", pop_data, DW'(16'h200 + i));
    end
    chk("R7 drained", occupancy, 0);
  endtask

  task automatic t_full_pushpop;
    apply_reset();
    for (int i = 0; i < DP; i++) push_word(DW'(16'h300 + i));
    push_valid = 1'b1; push_data = 16'h3AA; pop_req = 1'b1;
    @(posedge clk); #1;
    push_valid = 1'b0; pop_req = 1'b0;
    chk("R11 occupancy stays full", occupancy, DP);
    chk("R11 no overrun", ovr_status, 0);
    chk("R11 popped oldest", pop_data, 16'h300);
    for (int i = 1; i < DP; i++) begin
      pop_word();
      chk("R11 older words first", pop_data, DW'(16'h300 + i));
    end
    pop_word();
    chk("R11 pushed word last", pop_data, 16'h3AA);
  endtask

  task automatic t_empty_pop;
    apply_reset();
    push_word(16'h55);
    pop_word();
    chk("R2 single word", pop_data, 16'h55);
    pop_word();
    chk("R10 pop_data held", pop_data, 16'h55);
    chk("R10 occupancy zero", occupancy, 0);
  endtask

  task automatic t_mid_pushpop;
    apply_reset();
    push_word(16'h71); push_word(16'h72); push_word(16'h73);
    push_valid = 1'b1; push_data = 16'h74; pop_req = 1'b1;
    @(posedge clk); #1;
    push_valid = 1'b0; pop_req = 1'b0;
    chk("R12 occupancy unchanged", occupancy, 3);
    chk("R12 popped oldest", pop_data, 16'h71);
    chk("R4 flag low at 3", svc_flag, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_level_flag();
        t_mask();
        t_overrun();
        t_full_pushpop();
        t_empty_pop();
        t_mid_pushpop();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule